// File: doc/BRIEF.md
# Instanced Attribute Index Generator

This block maps a linear thread index onto the index of an attribute record. When threads are launched in instanced batches, each thread carries a single linear number. An attribute can be fetched by that number as it is. It can instead be fetched by its position inside a padded vertex batch, which is a modulo by an odd factor times a power of two. The third choice is the instance the thread belongs to, which is a division by a power of two or by any other constant. The caller computes the shift, the small odd factor and the reciprocal multiplier beforehand and presents them with each index. The block itself does not derive any constants.

The unit is a three-stage pipeline with no backpressure. A valid-qualified request goes in on every clock and the result comes out exactly three clocks later. Division by a general constant multiplies the index by a 32-bit reciprocal and keeps the upper half of the product. The top bit of that reciprocal is always treated as one. An optional round-down correction can follow, and a final right shift comes last. No shift is applied before the multiply.

Top module: `attr_index_gen`

## Requirements
- R1: A request with `in_valid` high sampled at clock edge k produces `out_valid` high, with its result on `out_index`, after edge k+3. `out_valid` is low after every edge k+3 whose edge k sampled `in_valid` low. Back-to-back requests are accepted on every cycle.
- R2: While `rst_n` is low, `out_valid` is low, whatever `in_valid` does.
- R3: Mode 0 (`in_mode` = 2'd0) is pass-through: the result equals the index.
- R4: Mode 1 (`in_mode` = 2'd1) is a modulo. The result is the index modulo (2m+1)·2^s, where m is `in_extra` (0 to 4, so the factor is 1, 3, 5, 7 or 9) and s is `in_shift`. This includes s = 0 and s = 31.
- R5: In mode 1, values of `in_extra` from 5 to 7 use a factor of 1, so the result is the index modulo 2^s.
- R6: Mode 2 (`in_mode` = 2'd2) is a power-of-two divide: the result is the index shifted right by `in_shift`.
- R7: Mode 3 (`in_mode` = 2'd3) is a reciprocal divide. Let M be `in_magic` with bit 31 forced to 1. The result is floor(index·M / 2^32) >> `in_shift`. Bit 31 of `in_magic` as supplied has no effect.
- R8: In mode 3 with `in_extra` equal to exactly 1, the round-down correction applies: the result is floor((index+1)·M / 2^32) >> `in_shift`. This is computed without overflow at index 0xFFFFFFFF. Any other `in_extra` value gives no correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request qualifier |
| in_index | input | 32 | Linear thread index |
| in_mode | input | 2 | 0 pass, 1 modulo, 2 shift divide, 3 reciprocal divide |
| in_shift | input | 5 | Power-of-two exponent (modulo) or right-shift amount |
| in_extra | input | 3 | Odd-factor selector (mode 1) or round-down flag (mode 3) |
| in_magic | input | 32 | Reciprocal multiplier; bit 31 treated as 1 |
| out_valid | output | 1 | Result qualifier, three cycles after the request |
| out_index | output | 32 | Attribute record index |

## Verification
The reciprocal path gets constants built from random divisors with the standard round-up/round-down selection. Its results are compared with exact integer division. A design that dropped the round-down increment would come out one low on about half of those divisors. A design that let bit 31 of the multiplier through as zero would return roughly half the quotient. Index 0xFFFFFFFF with the correction set checks for a 32-bit overflow of index+1, which would wrap the quotient to zero. The modulo path is tried with every odd factor, with factor codes 5 to 7, and with shifts 0 and 31; a mix-up of low bits and remainder gives values at or above the modulus. Bubbles and back-to-back streams expose an off-by-one latency or a valid signal that sticks.

// File: rtl/aig_pkg.sv
package aig_pkg;

  localparam int IDX_W   = 32;
  localparam int SHIFT_W = 5;
  localparam int EXTRA_W = 3;
  localparam int PROD_W  = 2 * IDX_W;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_MOD   = 2'd1,
    MODE_SHDIV = 2'd2,
    MODE_RCDIV = 2'd3
  } aig_mode_e;

  // Remainder of x by the odd factor selected by m (factor 1 for m = 0 or m > 4).
  function automatic logic [IDX_W-1:0] rem_by_odd(input logic [IDX_W-1:0] x,
                                                  input logic [EXTRA_W-1:0] m);
    logic [IDX_W-1:0] r;
    case (m)
      3'd1:    r = x % IDX_W'(3);
      3'd2:    r = x % IDX_W'(5);
      3'd3:    r = x % IDX_W'(7);
      3'd4:    r = x % IDX_W'(9);
      default: r = '0;
    endcase
    return r;
  endfunction

  // Product index*M, plus M once more when the round-down correction is on.
  function automatic logic [PROD_W-1:0] recip_product(input logic [IDX_W-1:0] idx,
                                                      input logic [IDX_W-1:0] mag,
                                                      input logic             rnd);
    logic [PROD_W-1:0] p;
    p = PROD_W'(idx) * PROD_W'(mag);
    if (rnd) p = p + PROD_W'(mag);
    return p;
  endfunction

endpackage

// File: rtl/aig_modulo.sv
module aig_modulo
  import aig_pkg::*;
#(
  parameter int W  = IDX_W,
  parameter int SW = SHIFT_W,
  parameter int EW = EXTRA_W
) (
  input  logic [W-1:0]  idx,
  input  logic [SW-1:0] shift,
  input  logic [EW-1:0] factor_sel,
  output logic [W-1:0]  result
);
  logic [W-1:0] low_mask;
  logic [W-1:0] upper;
  logic [W-1:0] upper_rem;

  assign low_mask  = ~({W{1'b1}} << shift);
  assign upper     = idx >> shift;
  assign upper_rem = rem_by_odd(upper, factor_sel);
  assign result    = (upper_rem << shift) | (idx & low_mask);
endmodule

// File: rtl/aig_recip_mul.sv
module aig_recip_mul
  import aig_pkg::*;
#(
  parameter int W = IDX_W,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  idx,
  input  logic [W-1:0]  mag_forced,
  input  logic          round_down,
  output logic [PW-1:0] product
);
  assign product = recip_product(idx, mag_forced, round_down);
endmodule

// File: rtl/attr_index_gen.sv
module attr_index_gen
  import aig_pkg::*;
#(
  parameter int W  = IDX_W,
  parameter int SW = SHIFT_W,
  parameter int EW = EXTRA_W,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_index,
  input  logic [1:0]    in_mode,
  input  logic [SW-1:0] in_shift,
  input  logic [EW-1:0] in_extra,
  input  logic [W-1:0]  in_magic,
  output logic          out_valid,
  output logic [W-1:0]  out_index
);
  // Stage 1: captured request, multiplier top bit forced.
  logic          s1_valid;
  logic [W-1:0]  s1_index;
  aig_mode_e     s1_mode;
  logic [SW-1:0] s1_shift;
  logic [EW-1:0] s1_extra;
  logic [W-1:0]  s1_magic;

  // Stage 2: full product and the non-multiply result.
  logic          s2_valid;
  aig_mode_e     s2_mode;
  logic [SW-1:0] s2_shift;
  logic [PW-1:0] s2_product;
  logic [W-1:0]  s2_simple;

  // Named internal events.
  logic          s1_round_down;
  logic [PW-1:0] mul_product;
  logic [W-1:0]  mod_result;
  logic [W-1:0]  simple_result;
  logic [W-1:0]  recip_quot;
  logic [W-1:0]  final_result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_index <= '0;
      s1_mode  <= MODE_PASS;
      s1_shift <= '0;
      s1_extra <= '0;
      s1_magic <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_index <= in_index;
      s1_mode  <= aig_mode_e'(in_mode);
      s1_shift <= in_shift;
      s1_extra <= in_extra;
      s1_magic <= {1'b1, in_magic[W-2:0]};
    end
  end

  assign s1_round_down = (s1_mode == MODE_RCDIV) && (s1_extra == EW'(1));

  aig_recip_mul #(.W(W)) u_mul (
    .idx        (s1_index),
    .mag_forced (s1_magic),
    .round_down (s1_round_down),
    .product    (mul_product)
  );

  aig_modulo #(.W(W), .SW(SW), .EW(EW)) u_mod (
    .idx        (s1_index),
    .shift      (s1_shift),
    .factor_sel (s1_extra),
    .result     (mod_result)
  );

  always_comb begin
    case (s1_mode)
      MODE_MOD:   simple_result = mod_result;
      MODE_SHDIV: simple_result = s1_index >> s1_shift;
      default:    simple_result = s1_index;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid   <= 1'b0;
      s2_mode    <= MODE_PASS;
      s2_shift   <= '0;
      s2_product <= '0;
      s2_simple  <= '0;
    end else begin
      s2_valid   <= s1_valid;
      s2_mode    <= s1_mode;
      s2_shift   <= s1_shift;
      s2_product <= mul_product;
      s2_simple  <= simple_result;
    end
  end

  assign recip_quot   = s2_product[PW-1:W] >> s2_shift;
  assign final_result = (s2_mode == MODE_RCDIV) ? recip_quot : s2_simple;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_index <= '0;
    end else begin
      out_valid <= s2_valid;
      out_index <= final_result;
    end
  end
endmodule

// File: rtl/aig_checker.sv
module aig_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_index,
  input logic [1:0]  in_mode,
  input logic [4:0]  in_shift,
  input logic [2:0]  in_extra,
  input logic        out_valid,
  input logic [31:0] out_index
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic        primed;
  logic [3:0]  odd_k;
  logic [63:0] mod_limit;
  assign primed = (since_rst == 2'd3);
  always_comb begin
    case (in_extra)
      3'd1: odd_k = 4'd3;
      3'd2: odd_k = 4'd5;
      3'd3: odd_k = 4'd7;
      3'd4: odd_k = 4'd9;
      default: odd_k = 4'd1;
    endcase
  end
  assign mod_limit = 64'(odd_k) << in_shift;

  p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (out_valid == $past(in_valid, 3)));

  p_reset_quiet_r2: assert property (@(posedge clk)
    !rst_n |-> !out_valid);

  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_valid && $past(in_mode, 3) == 2'd0) |-> (out_index == $past(in_index, 3)));

  p_mod_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_valid && $past(in_mode, 3) == 2'd1) |-> (64'(out_index) < $past(mod_limit, 3)));

  p_shift_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_valid && $past(in_mode, 3) == 2'd2) |-> (out_index == ($past(in_index, 3) >> $past(in_shift, 3))));

  p_recip_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_valid && $past(in_mode, 3) == 2'd3) |-> (out_index <= $past(in_index, 3)));
endmodule

bind attr_index_gen aig_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_index  (in_index),
  .in_mode   (in_mode),
  .in_shift  (in_shift),
  .in_extra  (in_extra),
  .out_valid (out_valid),
  .out_index (out_index)
);

// File: tb/attr_index_gen_tb.sv
module attr_index_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_index = '0;
  logic [1:0]  in_mode = '0;
  logic [4:0]  in_shift = '0;
  logic [2:0]  in_extra = '0;
  logic [31:0] in_magic = '0;
  logic        out_valid;
  logic [31:0] out_index;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit mon_en = 1'b0;

  logic [31:0] cur_exp = '0;
  string       cur_tag = "";
  logic        hv [3];
  logic [31:0] hx [3];
  string       ht [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  attr_index_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_index(in_index),
    .in_mode(in_mode), .in_shift(in_shift), .in_extra(in_extra),
    .in_magic(in_magic), .out_valid(out_valid), .out_index(out_index)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Output monitor: the request pushed three negedges ago is due now (R1).
  always @(negedge clk) begin
    if (mon_en) begin
      check("R1 valid", 32'(out_valid), 32'(hv[2]));
      if (hv[2] && out_valid) check(ht[2], out_index, hx[2]);
    end
    hv[2] = hv[1]; hx[2] = hx[1]; ht[2] = ht[1];
    hv[1] = hv[0]; hx[1] = hx[0]; ht[1] = ht[0];
    hv[0] = in_valid; hx[0] = cur_exp; ht[0] = cur_tag;
  end

  task automatic send(input logic [31:0] idx, input logic [1:0] mode, input logic [4:0] sh,
                      input logic [2:0] ex, input logic [31:0] mg,
                      input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    in_valid = 1'b1; in_index = idx; in_mode = mode; in_shift = sh;
    in_extra = ex; in_magic = mg; cur_exp = exp; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0; cur_tag = "";
    end
  endtask

  function automatic void mk_const(input int unsigned d, output logic [4:0] s,
                                   output logic [31:0] mg, output logic [2:0] ex);
    int sh;
    longint unsigned p, q, r, c;
    sh = 0;
    while ((64'd1 << (sh + 1)) <= 64'(d)) sh++;
    p = 64'd1 << (32 + sh);
    q = p / 64'(d);
    r = p % 64'(d);
    c = q + ((r != 0) ? 64'd1 : 64'd0);
    s = 5'(sh);
    if (r <= (64'd1 << sh)) begin mg = 32'(c - 1); ex = 3'd1; end
    else begin mg = 32'(c); ex = 3'd0; end
    mg[31] = 1'b0;
  endfunction

  function automatic logic [31:0] ref_mod(input logic [31:0] idx, input int k, input logic [4:0] s);
    return 32'(64'(idx) % (64'(k) << s));
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1; in_valid = 1'b1;
      @(negedge clk); check("R2 reset", 32'(out_valid), 32'd0);
    end
    @(posedge clk); #1; in_valid = 1'b0;
    idle(3);
    rst_n = 1'b1;
    mon_en = 1'b1;
  endtask

  task automatic t_pass();
    send(32'h0, 2'd0, 5'd7, 3'd2, 32'h1234, 32'h0, "R3 pass zero");
    send(32'hFFFF_FFFF, 2'd0, 5'd31, 3'd1, 32'h0, 32'hFFFF_FFFF, "R3 pass max");
    send(32'hDEAD_BEEF, 2'd0, 5'd3, 3'd4, 32'hFFFF_FFFF, 32'hDEAD_BEEF, "R3 pass pattern");
    idle(1);
  endtask

  task automatic t_modulo();
    int k;
    logic [31:0] x;
    for (int m = 0; m <= 4; m++) begin
      k = 2 * m + 1;
      foreach (hv[j]) begin end
      send(32'hFFFF_FFFF, 2'd1, 5'd0, 3'(m), 32'h0, ref_mod(32'hFFFF_FFFF, k, 5'd0), "R4 mod shift0 max");
      send(32'hFFFF_FFFF, 2'd1, 5'd31, 3'(m), 32'h0, ref_mod(32'hFFFF_FFFF, k, 5'd31), "R4 mod shift31");
      for (int t = 0; t < 6; t++) begin
        x = $urandom;
        send(x, 2'd1, 5'(t * 3), 3'(m), 32'h0, ref_mod(x, k, 5'(t * 3)), "R4 mod random");
      end
    end
    send(32'd70 + 32'd72 * 32'd5, 2'd1, 5'd3, 3'd4, 32'h0, 32'd70, "R4 mod padded batch");
    idle(2);
  endtask

  task automatic t_modulo_wide_sel();
    logic [31:0] x;
    for (int m = 5; m <= 7; m++) begin
      x = $urandom;
      send(x, 2'd1, 5'd6, 3'(m), 32'h0, x & 32'h3F, "R5 mod factor one");
      send(x, 2'd1, 5'd0, 3'(m), 32'h0, 32'h0, "R5 mod shift0 zero");
    end
    idle(1);
  endtask

  task automatic t_shift_div();
    logic [31:0] x;
    for (int s = 0; s < 32; s++) begin
      x = $urandom;
      send(x, 2'd2, 5'(s), 3'(s % 8), 32'h0, x >> s, "R6 shift divide");
    end
    send(32'hFFFF_FFFF, 2'd2, 5'd31, 3'd0, 32'h0, 32'h1, "R6 shift divide max");
    idle(1);
  endtask

  task automatic t_recip();
    int unsigned d;
    logic [4:0] s;
    logic [31:0] mg, x;
    logic [2:0] ex;
    int unsigned dl [8] = '{3, 5, 6, 7, 9, 10, 641, 1000003};
    for (int i = 0; i < 48; i++) begin
      if (i < 8) d = dl[i];
      else begin
        d = ($urandom % 32'd1048573) + 3;
        if ((d & (d - 1)) == 0) d = d + 1;
      end
      mk_const(d, s, mg, ex);
      x = $urandom;
      send(x, 2'd3, s, ex, mg, x / d, "R7 recip divide");
      send(32'hFFFF_FFFF, 2'd3, s, ex, mg, 32'hFFFF_FFFF / d, "R8 recip divide max index");
      send(x, 2'd3, s, ex, mg | 32'h8000_0000, x / d, "R7 recip divide bit31 set");
      send(d - 1, 2'd3, s, ex, mg, 32'h0, "R8 recip below divisor");
      send(d, 2'd3, s, ex, mg, 32'h1, "R8 recip equal divisor");
    end
    idle(2);
  endtask

  task automatic t_round_flag();
    logic [31:0] x, mg, exp0;
    logic [63:0] pr;
    for (int e = 0; e < 8; e++) begin
      x = $urandom;
      mg = $urandom;
      pr = 64'(x) * 64'({1'b1, mg[30:0]});
      if (e == 1) pr = pr + 64'({1'b1, mg[30:0]});
      exp0 = 32'(pr >> 32) >> 2;
      send(x, 2'd3, 5'd2, 3'(e), mg, exp0, (e == 1) ? "R8 round-down on" : "R8 round-down off");
    end
    idle(1);
  endtask

  task automatic t_bubbles();
    for (int i = 0; i < 10; i++) begin
      send(32'(i), 2'd0, 5'd0, 3'd0, 32'h0, 32'(i), "R1 bubble pattern");
      if (i % 3 == 0) idle(i % 2 + 1);
    end
    idle(4);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; hx[i] = '0; ht[i] = ""; end
    t_reset();
    t_pass();
    t_modulo();
    t_modulo_wide_sel();
    t_shift_div();
    t_recip();
    t_round_flag();
    t_bubbles();
    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=below 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule